// File: doc/BRIEF.md
# Continuous Repeat Test for a Random Word Stream

This block sits between a random word generator and the logic that consumes its output. Each word that arrives with its valid strobe is compared with the word that arrived before it. A word equal to its predecessor is a repeat. A repeat raises a sticky failure flag, and that word never reaches the consumer. A word that differs from its predecessor is passed on, registered, one cycle later.

When the enable input rises, the first word that arrives is not released. It is stored only as the reference for the comparison that follows. Taking the enable low drops the stored reference and the failure flag, so re-arming starts the sequence over. The flag can also be cleared by a pulse on the clear input. While the flag is set, words are still compared and the reference still moves forward, but nothing is forwarded.

Top module: `rct_stream_guard`

## Requirements
- R1: While reset is high, and after it is released, `out_valid` and `fail` are 0 until the first input word is processed.
- R2: The first word taken with `in_valid`=1 after enable rises, or after reset with enable high, is stored as the reference. It produces no `out_valid`, whatever its value.
- R3: A later word that differs from the reference produces `out_valid`=1 for exactly one cycle, in the cycle after the word is presented, with `out_data` equal to that word.
- R4: A later word equal to the reference sets `fail` in the cycle after it is presented, and that word produces no `out_valid`.
- R5: Every compared word becomes the new reference, including one that fails. The same value presented again after a failure is therefore a repeat again.
- R6: `fail` stays 1 until a cycle with `fail_clr`=1 or `en`=0. A word presented while `fail` is 1 is not forwarded, even when `fail_clr` is high in that same cycle.
- R7: With `en`=0, input words are ignored and `fail` is cleared one cycle later. After enable rises again, the first word is withheld as a fresh reference (R2).
- R8: When a repeat and `fail_clr` occur in the same cycle, `fail` is 1 afterwards.
- R9: `out_valid` is 0 in any cycle that follows a cycle without an accepted word (`en`=1 and `in_valid`=1). Consecutive passing words give consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low disarms and clears the test |
| in_valid | input | 1 | Input word strobe from the generator |
| in_data | input | DATA_W | Input random word |
| fail_clr | input | 1 | Clears the sticky failure flag |
| out_valid | output | 1 | One-cycle strobe for a forwarded word |
| out_data | output | DATA_W | Forwarded word, valid with `out_valid` |
| fail | output | 1 | Sticky repeat-failure flag |

## Verification
All results come out of output registers. A word presented before a rising edge therefore shows its effect on `out_valid`, `out_data` and `fail` just after that same edge, one cycle of latency. The bench changes inputs on the falling edge and lets one rising edge pass. It then checks the outputs on the next falling edge, before any input changes, so every check belongs to exactly one presented word. Reference updates (R5) have no output of their own. They are seen one word later, through whether that next word counts as a repeat.

// File: rtl/rct_pkg.sv
package rct_pkg;

    // Arming progress of the test.
    typedef enum logic [1:0] {
        ARM_OFF   = 2'd0,
        ARM_PRIME = 2'd1,
        ARM_LIVE  = 2'd2
    } arm_state_e;

    // Outcome of one presented word.
    typedef struct packed {
        logic load;     // word accepted, becomes reference
        logic pass;     // compared and differs from reference
        logic rep_hit;  // compared and equals reference
    } verdict_t;

    function automatic verdict_t make_verdict(
        input logic take,
        input logic live,
        input logic same
    );
        verdict_t v;
        v.load    = take;
        v.pass    = take && live && !same;
        v.rep_hit = take && live && same;
        return v;
    endfunction

    function automatic arm_state_e next_arm(
        input arm_state_e cur,
        input logic       en,
        input logic       take
    );
        arm_state_e n;
        if (!en) begin
            n = ARM_OFF;
        end else if (take) begin
            n = ARM_LIVE;
        end else if (cur == ARM_OFF) begin
            n = ARM_PRIME;
        end else begin
            n = cur;
        end
        return n;
    endfunction

endpackage

// File: rtl/rct_arm_fsm.sv
module rct_arm_fsm
    import rct_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic take,
    output logic live
);
    arm_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_OFF;
        end else begin
            state_q <= next_arm(state_q, en, take);
        end
    end

    assign live = (state_q == ARM_LIVE);
endmodule

// File: rtl/rct_ref_store.sv
module rct_ref_store #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              load,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] ref_q
);
    always_ff @(posedge clk) begin
        if (load) begin
            ref_q <= word;
        end
    end
endmodule

// File: rtl/rct_judge.sv
module rct_judge
    import rct_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              take,
    input  logic              live,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] ref_word,
    output verdict_t          verdict
);
    logic same;
    assign same    = (word == ref_word);
    assign verdict = make_verdict(take, live, same);
endmodule

// File: rtl/rct_fail_latch.sv
module rct_fail_latch (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic fail_q
);
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            fail_q <= 1'b0;
        end else if (set) begin
            fail_q <= 1'b1;
        end else if (clr) begin
            fail_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rct_stream_guard.sv
module rct_stream_guard
    import rct_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              fail_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              fail
);
    logic              take;
    logic              live;
    logic [DATA_W-1:0] ref_word;
    verdict_t          verdict;
    logic              ov_q;
    logic [DATA_W-1:0] od_q;

    assign take = en && in_valid;

    rct_arm_fsm u_arm (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .take (take),
        .live (live)
    );

    rct_ref_store #(.DATA_W(DATA_W)) u_ref (
        .clk   (clk),
        .load  (verdict.load),
        .word  (in_data),
        .ref_q (ref_word)
    );

    rct_judge #(.DATA_W(DATA_W)) u_judge (
        .take     (take),
        .live     (live),
        .word     (in_data),
        .ref_word (ref_word),
        .verdict  (verdict)
    );

    rct_fail_latch u_fail (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .set    (verdict.rep_hit),
        .clr    (fail_clr),
        .fail_q (fail)
    );

    // Forwarding is gated by the flag as it stands before this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q <= 1'b0;
            od_q <= '0;
        end else begin
            ov_q <= verdict.pass && !fail;
            if (verdict.pass && !fail) begin
                od_q <= in_data;
            end
        end
    end

    assign out_valid = ov_q;
    assign out_data  = od_q;
endmodule

// File: rtl/rct_guard_checker.sv
module rct_guard_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              fail_clr,
    input logic              out_valid,
    input logic              fail,
    input logic              live,
    input logic [DATA_W-1:0] ref_word
);
    a_r2_first_held: assert property (@(posedge clk) disable iff (rst)
        (en && in_valid && !live) |=> !out_valid);

    a_r4_repeat_flags: assert property (@(posedge clk) disable iff (rst)
        (en && in_valid && live && in_data == ref_word) |=> (fail && !out_valid));

    a_r5_ref_follows: assert property (@(posedge clk) disable iff (rst)
        (en && in_valid) |=> (ref_word == $past(in_data)));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && en && !fail_clr) |=> fail);

    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        fail |=> !out_valid);

    a_r7_off_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!fail && !out_valid && !live));

    a_r9_needs_word: assert property (@(posedge clk) disable iff (rst)
        !(en && in_valid) |=> !out_valid);
endmodule

bind rct_stream_guard rct_guard_checker #(.DATA_W(DATA_W)) u_guard_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .fail_clr  (fail_clr),
    .out_valid (out_valid),
    .fail      (fail),
    .live      (live),
    .ref_word  (ref_word)
);

// File: tb/rct_stream_guard_test.sv
`timescale 1ns/1ps
module rct_stream_guard_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         fail_clr = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         fail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rct_stream_guard #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
        .in_data(in_data), .fail_clr(fail_clr),
        .out_valid(out_valid), .out_data(out_data), .fail(fail)
    );

    typedef struct packed {
        logic         en;
        logic         vld;
        logic         clr;
        logic [W-1:0] d;
        logic         x_ov;
        logic [W-1:0] x_od;
        logic         x_f;
        logic [7:0]   req;
    } row_t;

    localparam int N = 15;
    localparam row_t TBL [N] = '{
        '{1'b1,1'b1,1'b0,32'hA1A1_0001,1'b0,32'h0,1'b0,8'd2},           // R2 first held
        '{1'b1,1'b1,1'b0,32'hB2B2_0002,1'b1,32'hB2B2_0002,1'b0,8'd3},   // R3 pass
        '{1'b1,1'b1,1'b0,32'hC3C3_0003,1'b1,32'hC3C3_0003,1'b0,8'd9},   // R9 back to back
        '{1'b1,1'b0,1'b0,32'hC3C3_0003,1'b0,32'h0,1'b0,8'd9},           // R9 no strobe
        '{1'b1,1'b1,1'b0,32'hC3C3_0003,1'b0,32'h0,1'b1,8'd4},           // R4 repeat
        '{1'b1,1'b1,1'b0,32'hD4D4_0004,1'b0,32'h0,1'b1,8'd6},           // R6 suppressed
        '{1'b1,1'b0,1'b1,32'h0,1'b0,32'h0,1'b0,8'd6},                   // R6 clear
        '{1'b1,1'b1,1'b0,32'hD4D4_0004,1'b0,32'h0,1'b1,8'd5},           // R5 ref moved
        '{1'b1,1'b1,1'b1,32'hE5E5_0005,1'b0,32'h0,1'b0,8'd6},           // R6 same-cycle clear
        '{1'b1,1'b1,1'b1,32'hE5E5_0005,1'b0,32'h0,1'b1,8'd8},           // R8 set wins
        '{1'b0,1'b1,1'b0,32'hF6F6_0006,1'b0,32'h0,1'b0,8'd7},           // R7 disabled
        '{1'b1,1'b1,1'b0,32'hF6F6_0006,1'b0,32'h0,1'b0,8'd7},           // R7 fresh ref
        '{1'b1,1'b1,1'b0,32'hF6F6_0006,1'b0,32'h0,1'b1,8'd7},           // R7 ref is new word
        '{1'b1,1'b0,1'b1,32'h0,1'b0,32'h0,1'b0,8'd6},                   // R6 clear
        '{1'b1,1'b1,1'b0,32'h0000_0007,1'b1,32'h0000_0007,1'b0,8'd3}    // R3 pass
    };

    task automatic check1(input string req, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic v, input logic c,
                         input logic [W-1:0] d);
        en = e; in_valid = v; fail_clr = c; in_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic ov,
                              input logic [W-1:0] od, input logic f);
        check1(req, "out_valid", {31'b0, out_valid}, {31'b0, ov});
        check1(req, "fail", {31'b0, fail}, {31'b0, f});
        if (ov) check1(req, "out_data", out_data, od);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        expect_out("R1", 1'b0, '0, 1'b0);   // R1 during reset
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, '0);
        expect_out("R1", 1'b0, '0, 1'b0);   // R1 after release

        for (int i = 0; i < N; i++) begin
            drive(TBL[i].en, TBL[i].vld, TBL[i].clr, TBL[i].d);
            expect_out($sformatf("R%0d", TBL[i].req), TBL[i].x_ov, TBL[i].x_od, TBL[i].x_f);
        end

        // R4 then R1: reset clears a set flag
        drive(1'b1, 1'b1, 1'b0, 32'h0000_0007);
        expect_out("R4", 1'b0, '0, 1'b1);
        rst = 1'b1;
        drive(1'b1, 1'b0, 1'b0, '0);
        expect_out("R1", 1'b0, '0, 1'b0);
        rst = 1'b0;
        // R2 after reset with enable held high
        drive(1'b1, 1'b1, 1'b0, 32'h1234_5678);
        expect_out("R2", 1'b0, '0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 32'h8765_4321);
        expect_out("R3", 1'b1, 32'h8765_4321, 1'b0);
        // R9 single pulse
        drive(1'b1, 1'b0, 1'b0, 32'h8765_4321);
        expect_out("R9", 1'b0, '0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule